// File: doc/BRIEF.md
# Sliding-Origin Windowed Histogram Engine

This block turns a raster-ordered pixel stream, one vertical stripe of an image at a time, into one full windowed histogram per accepted pixel. For each input pixel at stripe position (row, column), it produces the histogram of the square window whose bottom-right corner is that pixel. The window is centred on the target pixel half a window up and to the left. A downstream range-kernel stage consumes the bin vector to form a filtered value.

Internally the block keeps one line of integral histograms, one per stripe column. The origin of these histograms slides down with the window, so each stored entry covers only the last WIN rows. Integration and extraction happen in the same cycle. The new integral histogram for the current column is built from two one-cycle delay registers, one entry read from the line store and the selected-bin increments. It then replaces the stale entry in that column's slot. The window histogram is the new entry minus the stored entry WIN columns to the left. A per-column pixel history of WIN rows supplies the pixel that leaves the top of the window.

A parameter selects the bin contents. In count mode each pixel adds 1 to its bin. In intensity mode each pixel adds its own value to its bin, and bins are PIX_W bits wider.

Top module: `slide_hist`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, out_valid is 0.
- R2: In count mode (INTENSITY=0), bin k of out_bins (bits k*BW to k*BW+BW-1) equals the number of pixels in rows r-WIN+1..r and columns c-WIN+1..c of the current stripe whose upper log2(NBINS) bits equal k. Here (r, c) is the position of the accepted input.
- R3: In intensity mode (INTENSITY=1), bin k equals the sum of the values of those same pixels.
- R4: out_valid is 1 in the cycle after an accepted input exactly when that input has row >= WIN-1 and column >= WIN-1. Windows that reach above the stripe top or left of column 0 are reported with out_valid 0.
- R5: With out_valid, out_row equals the input row minus (WIN-1)/2, and out_col equals the input column minus (WIN-1)/2. These are the coordinates of the window centre.
- R6: Every result appears on the clock edge that follows the accepting edge. A cycle without in_valid gives out_valid 0 in the next cycle.
- R7: Bins reach their extreme values without overflow. In count mode a window of WIN*WIN pixels in one bin reads WIN*WIN. In intensity mode a window of all-maximum pixels reads WIN*WIN*(2^PIX_W-1).
- R8: Idle cycles inserted between accepted pixels do not change any later result.
- R9: A stripe that starts again at row 0 is integrated afresh. No pixel of an earlier stripe contributes to its histograms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel accepted this cycle |
| in_pix | input | PIX_W | Pixel intensity |
| in_row | input | ROW_W | Row of the pixel within the stripe, starting at 0 |
| in_col | input | $clog2(STRIPE_W) | Column of the pixel within the stripe, 0..STRIPE_W-1 in raster order |
| out_valid | output | 1 | Window histogram valid |
| out_row | output | ROW_W | Row of the window centre |
| out_col | output | $clog2(STRIPE_W) | Column of the window centre |
| out_bins | output | NBINS*BW | Bin vector, bin k in bits k*BW upward |

## Verification
A corrupted stored integral histogram does not stay local. The error is carried right along its row by the left delay register and down into every later row through the up/up-left difference. At the ports it appears in the next cycle, in every window whose column span straddles the faulty column. Windows lying wholly to its right subtract it away. A wrong entry in the pixel history stays hidden for WIN rows and then shows as a bin that fails to drop a departing pixel. For this reason the bench compares every window of several full stripes against a brute-force count, and not just a few samples.

// File: rtl/slide_hist.sv
module slide_hist #(
  parameter int NBINS     = 64,
  parameter int PIX_W     = 8,
  parameter int WIN       = 31,
  parameter int STRIPE_W  = 64,
  parameter int ROW_W     = 11,
  parameter int INTENSITY = 0,
  localparam int CW       = $clog2(STRIPE_W),
  localparam int CNT_W    = $clog2(WIN*WIN+1),
  localparam int BW       = (INTENSITY != 0) ? CNT_W + PIX_W : CNT_W,
  localparam int HW       = NBINS*BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [ROW_W-1:0] in_row,
  input  logic [CW-1:0]    in_col,
  output logic             out_valid,
  output logic [ROW_W-1:0] out_row,
  output logic [CW-1:0]    out_col,
  output logic [HW-1:0]    out_bins
);
  localparam int HALF = (WIN-1)/2;
  localparam int BIW  = $clog2(NBINS);
  localparam int PHW  = WIN*PIX_W;

  // one integral histogram per stripe column, origin WIN-1 rows above
  logic [HW-1:0]  ih_mem [STRIPE_W];
  logic [PHW-1:0] px_mem [STRIPE_W];
  logic [HW-1:0]  left_q, upl_q;

  wire first_col = (in_col == '0);
  wire first_row = (in_row == '0);
  wire drop      = (in_row >= ROW_W'(WIN));
  wire has_far   = (in_col >= CW'(WIN));
  wire [CW-1:0] far_col = in_col - CW'(WIN);

  wire [HW-1:0]  up_rd  = first_row ? '0 : ih_mem[in_col];
  wire [HW-1:0]  far_rd = has_far ? ih_mem[far_col] : '0;
  wire [HW-1:0]  left   = first_col ? '0 : left_q;
  wire [HW-1:0]  upl    = first_col ? '0 : upl_q;
  wire [PHW-1:0] px_col = px_mem[in_col];
  wire [PIX_W-1:0] old_pix = px_col[PHW-1 -: PIX_W];

  wire [BIW-1:0] new_sel = in_pix[PIX_W-1 -: BIW];
  wire [BIW-1:0] old_sel = old_pix[PIX_W-1 -: BIW];
  wire [BW-1:0]  inc_new = (INTENSITY != 0) ? BW'(in_pix)  : BW'(1);
  wire [BW-1:0]  inc_old = (INTENSITY != 0) ? BW'(old_pix) : BW'(1);

  logic [HW-1:0] new_ih, win_h;

  // selected-bin adders: all bins in parallel; arithmetic wraps in BW bits
  for (genvar k = 0; k < NBINS; k++) begin : g_bin
    wire [BW-1:0] add = (new_sel == BIW'(k)) ? inc_new : '0;
    wire [BW-1:0] sub = (drop && old_sel == BIW'(k)) ? inc_old : '0;
    assign new_ih[k*BW +: BW] = left[k*BW +: BW] + up_rd[k*BW +: BW]
                              - upl[k*BW +: BW] + add - sub;
    assign win_h[k*BW +: BW]  = new_ih[k*BW +: BW] - far_rd[k*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      ih_mem[in_col] <= new_ih;
      px_mem[in_col] <= {px_col[PHW-PIX_W-1:0], in_pix};
      left_q         <= new_ih;
      upl_q          <= up_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid && in_row >= ROW_W'(WIN-1)
                                      && in_col >= CW'(WIN-1);
  end

  always_ff @(posedge clk) begin
    out_row  <= in_row - ROW_W'(HALF);
    out_col  <= in_col - CW'(HALF);
    out_bins <= win_h;
  end
endmodule

// File: rtl/slide_hist_chk.sv
module slide_hist_chk #(
  parameter int WIN       = 31,
  parameter int ROW_W     = 11,
  parameter int CW        = 6,
  parameter int NBINS     = 64,
  parameter int BW        = 10,
  parameter int INTENSITY = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [ROW_W-1:0]    in_row,
  input logic [CW-1:0]       in_col,
  input logic                out_valid,
  input logic [ROW_W-1:0]    out_row,
  input logic [CW-1:0]       out_col,
  input logic [NBINS*BW-1:0] out_bins
);
  localparam int HALF = (WIN-1)/2;

  int tot;
  always_comb begin
    tot = 0;
    for (int k = 0; k < NBINS; k++) tot += int'(out_bins[k*BW +: BW]);
  end

  p_top_rows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row < ROW_W'(WIN-1)) |=> !out_valid);

  p_left_cols_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_col < CW'(WIN-1)) |=> !out_valid);

  p_centre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row >= ROW_W'(WIN-1) && in_col >= CW'(WIN-1)) |=>
      (out_valid && out_row == $past(in_row) - ROW_W'(HALF)
                 && out_col == $past(in_col) - CW'(HALF)));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_total_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && INTENSITY == 0) |-> tot == WIN*WIN);
endmodule

bind slide_hist slide_hist_chk #(
  .WIN(WIN), .ROW_W(ROW_W), .CW(CW), .NBINS(NBINS), .BW(BW), .INTENSITY(INTENSITY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row), .in_col(in_col),
  .out_valid(out_valid), .out_row(out_row), .out_col(out_col), .out_bins(out_bins)
);

// File: tb/tb_slide_hist.sv
`timescale 1ns/1ps
module tb_slide_hist;
  localparam int NB   = 16;
  localparam int PW   = 8;
  localparam int WN   = 5;
  localparam int SW   = 12;
  localparam int RW   = 8;
  localparam int CW   = $clog2(SW);
  localparam int BWC  = $clog2(WN*WN+1);
  localparam int BWI  = BWC + PW;
  localparam int HALF = (WN-1)/2;
  localparam int ROWS = 10;
  localparam int SH   = PW - $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic [RW-1:0] in_row = '0;
  logic [CW-1:0] in_col = '0;

  logic out_valid_c, out_valid_i;
  logic [RW-1:0] out_row_c, out_row_i;
  logic [CW-1:0] out_col_c, out_col_i;
  logic [NB*BWC-1:0] bins_c;
  logic [NB*BWI-1:0] bins_i;

  always #2.5 clk = ~clk;

  slide_hist #(.NBINS(NB), .PIX_W(PW), .WIN(WN), .STRIPE_W(SW), .ROW_W(RW), .INTENSITY(0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix), .in_row(in_row),
    .in_col(in_col), .out_valid(out_valid_c), .out_row(out_row_c), .out_col(out_col_c),
    .out_bins(bins_c));

  slide_hist #(.NBINS(NB), .PIX_W(PW), .WIN(WN), .STRIPE_W(SW), .ROW_W(RW), .INTENSITY(1)) dut_int (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix), .in_row(in_row),
    .in_col(in_col), .out_valid(out_valid_i), .out_row(out_row_i), .out_col(out_col_i),
    .out_bins(bins_i));

  int checks = 0;
  int fails  = 0;
  string phase = "R1";
  int img [0:ROWS-1][0:SW-1];
  bit ev = 1'b0;
  bit was_idle = 1'b1;
  int er, ec;
  int eb_c [NB];
  int eb_i [NB];

  task automatic compare_one(input bit intens);
    bit v; int r, c, got, bad;
    v = intens ? out_valid_i : out_valid_c;
    r = intens ? int'(out_row_i) : int'(out_row_c);
    c = intens ? int'(out_col_i) : int'(out_col_c);
    checks++;
    bad = 0;
    if (v !== ev) begin
      bad = 1;
      $display("FAIL %s (phase %s) out_valid actual=%0b expected=%0b",
               was_idle ? "R6" : (phase == "R1" ? "R1" : "R4"), phase, v, ev);
    end else if (ev) begin
      if (r != er || c != ec) begin
        bad = 1;
        $display("FAIL R5 (phase %s) centre actual=(%0d,%0d) expected=(%0d,%0d)",
                 phase, r, c, er, ec);
      end
      for (int k = 0; k < NB; k++) begin
        got = intens ? int'(bins_i[k*BWI +: BWI]) : int'(bins_c[k*BWC +: BWC]);
        if (bad == 0 && got != (intens ? eb_i[k] : eb_c[k])) begin
          bad = 1;
          $display("FAIL %s (phase %s) bin %0d at (%0d,%0d) actual=%0d expected=%0d",
                   intens ? "R3" : "R2", phase, k, er, ec, got,
                   intens ? eb_i[k] : eb_c[k]);
        end
      end
    end
    if (bad != 0) fails++;
  endtask

  task automatic step(input bit v, input int p, input int r, input int c);
    @(negedge clk);
    compare_one(1'b0);
    compare_one(1'b1);
    in_valid = v;
    in_pix   = PW'(p);
    in_row   = RW'(r);
    in_col   = CW'(c);
    was_idle = !v;
    if (v) img[r][c] = p;
    ev = v && r >= WN-1 && c >= WN-1;
    if (ev) begin
      er = r - HALF;
      ec = c - HALF;
      for (int k = 0; k < NB; k++) begin eb_c[k] = 0; eb_i[k] = 0; end
      for (int rr = r-WN+1; rr <= r; rr++)
        for (int cc = c-WN+1; cc <= c; cc++) begin
          eb_c[img[rr][cc] >> SH] += 1;
          eb_i[img[rr][cc] >> SH] += img[rr][cc];
        end
    end
  endtask

  // kind 0 random, 1 all maximum, 2 ramp, 3 checker of extreme bins
  task automatic run_stripe(input int kind, input bit gaps);
    int p;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < SW; c++) begin
        case (kind)
          0: p = int'($urandom % 256);
          1: p = 255;
          2: p = (r*7 + c*13) % 256;
          default: p = ((r + c) % 2 == 0) ? 3 : 250;
        endcase
        if (gaps && ($urandom % 3 == 0)) step(1'b0, 0, 0, 0);
        step(1'b1, p, r, c);
      end
    step(1'b0, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet output after reset
    phase = "R1";
    repeat (3) step(1'b0, 0, 0, 0);
    // R2, R3, R4, R5: random stripe, contiguous
    phase = "R2";
    run_stripe(0, 1'b0);
    // R7: every window saturates one bin
    phase = "R7";
    run_stripe(1, 1'b0);
    // R9: new stripe after the saturated one must not see its pixels
    phase = "R9";
    run_stripe(2, 1'b0);
    // R8 and R6: idle cycles between pixels
    phase = "R8";
    run_stripe(0, 1'b1);
    // R2: two extreme bins alternating
    phase = "R2";
    run_stripe(3, 1'b0);
    step(1'b0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule